// File: doc/BRIEF.md
# Idle-Gated Capture Controller

This block decides when a bus performance monitor collects statistics. Software talks to it through a small AXI-lite register port. It writes a control word to ask for a start, a stop or a clear. The block also watches a read-only tap of a full AXI bus. It tracks whether that bus has drained, and it changes its `capturing` enable only when the bus is idle. A burst is therefore never counted in part. While capturing, it counts active cycles. Companion statistic counters use only `capturing` and the one-cycle `clear_pulse`.

The trigger is a four-state machine:

- OFF: not capturing.
- ARM: a start is pending.
- ON: capturing.
- DRAIN: capturing while a stop is pending.

The transitions are:

- A clear command sends every state to OFF.
- A run command moves OFF to ARM and DRAIN to ON. ARM and ON stay where they are.
- A halt command moves ARM to OFF and ON to DRAIN. OFF and DRAIN stay where they are.
- Without a command, ARM moves to ON and DRAIN moves to OFF once the registered idle flag is set.

The idle tracker keeps three counts of outstanding transfers:

- accepted write addresses;
- write bursts whose last beat was taken;
- accepted read addresses.

Top module: `capture_ctrl`

## Requirements
- R1: After reset, `capturing`, `clear_pulse`, `s_bvalid` and `s_rvalid` are low. The active-time word and the control word both read zero.
- R2: An AXI-lite write is accepted (`s_awready` = `s_wready` = 1) only in a cycle where address and data are both valid and no unacknowledged response is pending. `s_bvalid` is high in the cycle after acceptance. `s_bresp` and `s_rresp` are always 2'b00.
- R3: The control word is the last word, byte address 124 (word index 31). A write there with `s_wstrb[0]` = 1 is a command. Data bit 0 = 1 means run and bit 0 = 0 means halt. Bit 1 = 1 together with bit 0 = 0 (value 2) also means clear. A write with `s_wstrb[0]` = 0, or a write to any other address, has no effect.
- R4: The bus-idle flag is registered and reset to 1. It drops after any cycle with AWVALID, WVALID or ARVALID high on the tap. It rises again after a cycle in which that cycle's completing handshake brings all three outstanding counts to zero. The completing handshake is B for the two write counts and R with RLAST for the read count.
- R5: A run command moves OFF to ARM. ARM moves to ON on the first clock edge at which the idle flag is set. `capturing` is high in ON and DRAIN. With an idle bus, `capturing` goes high one cycle after the accepting edge has passed, that is, after the next edge.
- R6: A halt command in ON moves to DRAIN, and `capturing` stays high. DRAIN moves to OFF on the first edge at which the idle flag is set.
- R7: The active-time count (word 0) increases by one on every edge where `capturing` is high. It holds its value while `capturing` is low.
- R8: A clear command forces OFF at the accepting edge. It raises `clear_pulse` for exactly the next cycle, and that cycle ends with the active-time count at zero.
- R9: The control word reads {29'b0, capturing, clear_pulse, start pending (state ARM)}. That is bit 0 = start pending, bit 1 = clear pulse, bit 2 = capturing. Words other than 0 and 31 read zero. Read data appears with `s_rvalid` in the cycle after `s_arvalid` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address accepted |
| s_awaddr | input | ADDR_W | Register write byte address |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data accepted |
| s_wdata | input | 32 | Register write data |
| s_wstrb | input | 4 | Register write byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address accepted |
| s_araddr | input | ADDR_W | Register read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| m_awvalid | input | 1 | Tap: write address valid |
| m_awready | input | 1 | Tap: write address ready |
| m_wvalid | input | 1 | Tap: write data valid |
| m_wready | input | 1 | Tap: write data ready |
| m_wlast | input | 1 | Tap: last write beat |
| m_bvalid | input | 1 | Tap: write response valid |
| m_bready | input | 1 | Tap: write response ready |
| m_arvalid | input | 1 | Tap: read address valid |
| m_arready | input | 1 | Tap: read address ready |
| m_rvalid | input | 1 | Tap: read data valid |
| m_rready | input | 1 | Tap: read data ready |
| m_rlast | input | 1 | Tap: last read beat |
| capturing | output | 1 | Statistics enable |
| clear_pulse | output | 1 | One-cycle counter clear |
| active_time | output | CNT_W | Cycles spent capturing |

## Verification
The bench builds the block with ADDR_W = 7, CNT_W = 16 and OUT_W = 4. With the 7-bit address, the control word sits at the all-ones word index, so the decode of the highest word is exercised next to a plain unmapped word.

The narrow counters keep every outstanding count and the active-time value small and exact. The bench can therefore predict active time by counting `capturing` cycles itself. Pending start and pending stop are both exercised against a tap held busy by read, write-address and write-data traffic.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        CAP_OFF   = 2'd0,
        CAP_ARM   = 2'd1,
        CAP_ON    = 2'd2,
        CAP_DRAIN = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic valid;
        logic run;
        logic clear;
    } cap_cmd_t;

    localparam int NUM_PEND = 3;

endpackage

// File: rtl/cap_pend_cnt.sv
module cap_pend_cnt #(
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic             drains,
    output logic [OUT_W-1:0] count
);
    logic [OUT_W-1:0] step;

    assign step   = {{(OUT_W-1){1'b0}}, dec};
    assign drains = (count == step);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + OUT_W'(1);
        end else if (dec && !inc) begin
            count <= count - OUT_W'(1);
        end
    end
endmodule

// File: rtl/cap_idle_track.sv
module cap_idle_track
    import cap_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aw_valid,
    input  logic aw_ready,
    input  logic w_valid,
    input  logic w_ready,
    input  logic w_last,
    input  logic b_valid,
    input  logic b_ready,
    input  logic ar_valid,
    input  logic ar_ready,
    input  logic r_valid,
    input  logic r_ready,
    input  logic r_last,
    output logic idle_o
);
    logic [NUM_PEND-1:0] inc_v, dec_v, drains_v;
    logic                b_hs, r_end, any_req, idle_q;

    assign b_hs    = b_valid && b_ready;
    assign r_end   = r_valid && r_ready && r_last;
    assign any_req = aw_valid || w_valid || ar_valid;

    // slot 0: write addresses, slot 1: finished write bursts, slot 2: reads
    assign inc_v = {ar_valid && ar_ready,
                    w_valid && w_ready && w_last,
                    aw_valid && aw_ready};
    assign dec_v = {r_end, b_hs, b_hs};

    for (genvar g = 0; g < NUM_PEND; g++) begin : g_pend
        logic [OUT_W-1:0] cnt_unused;
        cap_pend_cnt #(.OUT_W(OUT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc_v[g]),
            .dec    (dec_v[g]),
            .drains (drains_v[g]),
            .count  (cnt_unused)
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b1;
        end else if (any_req) begin
            idle_q <= 1'b0;
        end else if (&drains_v) begin
            idle_q <= 1'b1;
        end
    end

    assign idle_o = idle_q;

    // R4
    busy_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> !idle_o);

    // R4
    idle_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(!any_req));
endmodule

// File: rtl/cap_trigger.sv
module cap_trigger
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cap_cmd_t         cmd,
    input  logic             bus_idle,
    output logic             capturing,
    output logic             armed,
    output logic             clear_pulse,
    output logic [CNT_W-1:0] active_cnt
);
    cap_state_e st_q, st_d;
    logic       clear_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (cmd.valid && cmd.clear) begin
            st_d = CAP_OFF;
        end else if (cmd.valid) begin
            unique case (st_q)
                CAP_OFF:   st_d = cmd.run ? CAP_ARM : CAP_OFF;
                CAP_ARM:   st_d = cmd.run ? CAP_ARM : CAP_OFF;
                CAP_ON:    st_d = cmd.run ? CAP_ON  : CAP_DRAIN;
                CAP_DRAIN: st_d = cmd.run ? CAP_ON  : CAP_DRAIN;
                default:   st_d = CAP_OFF;
            endcase
        end else begin
            unique case (st_q)
                CAP_ARM:   if (bus_idle) st_d = CAP_ON;
                CAP_DRAIN: if (bus_idle) st_d = CAP_OFF;
                default:   st_d = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CAP_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (st_q)
            CAP_OFF:   begin capturing = 1'b0; armed = 1'b0; end
            CAP_ARM:   begin capturing = 1'b0; armed = 1'b1; end
            CAP_ON:    begin capturing = 1'b1; armed = 1'b0; end
            CAP_DRAIN: begin capturing = 1'b1; armed = 1'b0; end
            default:   begin capturing = 1'b0; armed = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_q <= 1'b0;
        end else begin
            clear_q <= cmd.valid && cmd.clear;
        end
    end

    assign clear_pulse = clear_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_q) begin
            active_cnt <= '0;
        end else if (capturing) begin
            active_cnt <= active_cnt + CNT_W'(1);
        end
    end

    // R5
    start_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capturing) |-> $past(bus_idle));

    // R6
    stop_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(capturing) |-> ($past(bus_idle) || $past(cmd.valid && cmd.clear)));

    // R7
    active_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing && !clear_pulse) |=> (active_cnt == $past(active_cnt) + CNT_W'(1)));

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capturing && !clear_pulse) |=> $stable(active_cnt));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> (active_cnt == '0));
endmodule

// File: rtl/cap_regif.sv
module cap_regif
    import cap_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [31:0]       s_rdata,
    input  logic [CNT_W-1:0]  active_cnt,
    input  logic              capturing,
    input  logic              armed,
    input  logic              clear_pulse,
    output cap_cmd_t          cmd
);
    localparam int                WORD_W   = ADDR_W - 2;
    localparam logic [WORD_W-1:0] CTRL_IDX = {WORD_W{1'b1}};
    localparam logic [WORD_W-1:0] ACT_IDX  = '0;

    logic              wr_go, rd_go, bvalid_q, rvalid_q;
    logic [WORD_W-1:0] aw_word, ar_word;
    logic [31:0]       rd_mux, rdata_q;
    logic              addr_lsb_unused;
    logic              strb_unused;
    logic              data_unused;

    assign aw_word         = s_awaddr[ADDR_W-1:2];
    assign ar_word         = s_araddr[ADDR_W-1:2];
    assign addr_lsb_unused = |{s_awaddr[1:0], s_araddr[1:0]};
    assign strb_unused     = |s_wstrb[3:1];
    assign data_unused     = |s_wdata[31:2];

    assign wr_go     = s_awvalid && s_wvalid && (!bvalid_q || s_bready);
    assign s_awready = wr_go;
    assign s_wready  = wr_go;

    assign cmd.valid = wr_go && (aw_word == CTRL_IDX) && s_wstrb[0];
    assign cmd.run   = s_wdata[0];
    assign cmd.clear = s_wdata[1] && !s_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid_q <= 1'b0;
        end else if (wr_go) begin
            bvalid_q <= 1'b1;
        end else if (s_bready) begin
            bvalid_q <= 1'b0;
        end
    end
    assign s_bvalid = bvalid_q;

    assign rd_go     = s_arvalid && (!rvalid_q || s_rready);
    assign s_arready = rd_go;

    always_comb begin
        if (ar_word == ACT_IDX) begin
            rd_mux = 32'(active_cnt);
        end else if (ar_word == CTRL_IDX) begin
            rd_mux = {29'b0, capturing, clear_pulse, armed};
        end else begin
            rd_mux = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_go) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_mux;
        end else if (s_rready) begin
            rvalid_q <= 1'b0;
        end
    end
    assign s_rvalid = rvalid_q;
    assign s_rdata  = rdata_q;

    // R2
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_bvalid) |-> $past(s_awvalid && s_wvalid));

    // R9
    read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_rvalid) |-> $past(s_arvalid));
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
    import cap_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 32,
    parameter int OUT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    input  logic              m_awvalid,
    input  logic              m_awready,
    input  logic              m_wvalid,
    input  logic              m_wready,
    input  logic              m_wlast,
    input  logic              m_bvalid,
    input  logic              m_bready,
    input  logic              m_arvalid,
    input  logic              m_arready,
    input  logic              m_rvalid,
    input  logic              m_rready,
    input  logic              m_rlast,
    output logic              capturing,
    output logic              clear_pulse,
    output logic [CNT_W-1:0]  active_time
);
    cap_cmd_t cmd;
    logic     bus_idle, armed;

    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;

    cap_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_awvalid   (s_awvalid),
        .s_awready   (s_awready),
        .s_awaddr    (s_awaddr),
        .s_wvalid    (s_wvalid),
        .s_wready    (s_wready),
        .s_wdata     (s_wdata),
        .s_wstrb     (s_wstrb),
        .s_bvalid    (s_bvalid),
        .s_bready    (s_bready),
        .s_arvalid   (s_arvalid),
        .s_arready   (s_arready),
        .s_araddr    (s_araddr),
        .s_rvalid    (s_rvalid),
        .s_rready    (s_rready),
        .s_rdata     (s_rdata),
        .active_cnt  (active_time),
        .capturing   (capturing),
        .armed       (armed),
        .clear_pulse (clear_pulse),
        .cmd         (cmd)
    );

    cap_idle_track #(.OUT_W(OUT_W)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .aw_valid (m_awvalid),
        .aw_ready (m_awready),
        .w_valid  (m_wvalid),
        .w_ready  (m_wready),
        .w_last   (m_wlast),
        .b_valid  (m_bvalid),
        .b_ready  (m_bready),
        .ar_valid (m_arvalid),
        .ar_ready (m_arready),
        .r_valid  (m_rvalid),
        .r_ready  (m_rready),
        .r_last   (m_rlast),
        .idle_o   (bus_idle)
    );

    cap_trigger #(.CNT_W(CNT_W)) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .bus_idle    (bus_idle),
        .capturing   (capturing),
        .armed       (armed),
        .clear_pulse (clear_pulse),
        .active_cnt  (active_time)
    );
endmodule

// File: tb/sim_capture_ctrl.sv
module sim_capture_ctrl;
    localparam int AW = 7;
    localparam int CW = 16;
    localparam int OW = 4;
    localparam logic [AW-1:0] A_CTRL = 7'd124;
    localparam logic [AW-1:0] A_ACT  = 7'd0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    wstrb = '0;
    logic          awready, wready, bvalid, arready, rvalid;
    logic [1:0]    bresp, rresp;
    logic [31:0]   rdata;
    logic m_awv = 0, m_awr = 0, m_wv = 0, m_wr = 0, m_wl = 0, m_bv = 0, m_br = 0;
    logic m_arv = 0, m_arr = 0, m_rv = 0, m_rr = 0, m_rl = 0;
    logic          capturing, clear_pulse;
    logic [CW-1:0] active_time;

    capture_ctrl #(.ADDR_W(AW), .CNT_W(CW), .OUT_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
        .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
        .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
        .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
        .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
        .m_awvalid(m_awv), .m_awready(m_awr), .m_wvalid(m_wv), .m_wready(m_wr),
        .m_wlast(m_wl), .m_bvalid(m_bv), .m_bready(m_br),
        .m_arvalid(m_arv), .m_arready(m_arr), .m_rvalid(m_rv), .m_rready(m_rr),
        .m_rlast(m_rl),
        .capturing(capturing), .clear_pulse(clear_pulse), .active_time(active_time)
    );

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int cap_seen = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mon_exp;
    string       mon_tag;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference count of cycles with capturing high
    always @(negedge clk) begin
        if (clear_pulse) cap_seen = 0;
        else if (capturing) cap_seen = cap_seen + 1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rvalid && rready) begin
            if (exp_q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL R9 unexpected read actual=%0h expected=none", rdata);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                check(mon_tag, rdata, mon_exp);
                check("R2 rresp", {30'b0, rresp}, 32'd0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected<20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        arvalid = 1; araddr = a;
        @(posedge clk);
        #1 arvalid = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awvalid = 1; wvalid = 1; awaddr = a; wdata = d; wstrb = s;
        @(posedge clk);
        #1 awvalid = 0; wvalid = 0;
    endtask

    task automatic mon_ar();
        @(negedge clk); m_arv = 1; m_arr = 1;
        @(posedge clk); #1 m_arv = 0; m_arr = 0;
    endtask
    task automatic mon_rlast();
        @(negedge clk); m_rv = 1; m_rr = 1; m_rl = 1;
        @(posedge clk); #1 m_rv = 0; m_rr = 0; m_rl = 0;
    endtask
    task automatic mon_aw();
        @(negedge clk); m_awv = 1; m_awr = 1;
        @(posedge clk); #1 m_awv = 0; m_awr = 0;
    endtask
    task automatic mon_wlast();
        @(negedge clk); m_wv = 1; m_wr = 1; m_wl = 1;
        @(posedge clk); #1 m_wv = 0; m_wr = 0; m_wl = 0;
    endtask
    task automatic mon_b();
        @(negedge clk); m_bv = 1; m_br = 1;
        @(posedge clk); #1 m_bv = 0; m_br = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 capturing", {31'b0, capturing}, 0);
        check("R1 clear_pulse", {31'b0, clear_pulse}, 0);
        check("R1 bvalid", {31'b0, bvalid}, 0);
        check("R1 rvalid", {31'b0, rvalid}, 0);
        check("R1 active port", 32'(active_time), 0);
        rd(A_CTRL, 32'd0, "R1 ctrl read");
        rd(A_ACT, 32'd0, "R1 active read");
        rd(7'd28, 32'd0, "R9 unmapped read");

        // R2: address without data is not accepted
        @(negedge clk);
        awvalid = 1; awaddr = A_CTRL; wdata = 32'd1; wstrb = 4'b0001;
        @(negedge clk);
        check("R2 awready alone", {31'b0, awready}, 0);
        check("R2 wready alone", {31'b0, wready}, 0);
        @(negedge clk);
        check("R2 no effect before data", {31'b0, capturing}, 0);
        wvalid = 1;
        @(posedge clk);
        #1 awvalid = 0; wvalid = 0;
        @(negedge clk);
        check("R2 bvalid after accept", {31'b0, bvalid}, 1);
        check("R2 bresp", {30'b0, bresp}, 0);
        // R5 start with idle bus: ARM now, ON after next edge
        check("R5 not yet capturing", {31'b0, capturing}, 0);
        @(negedge clk);
        check("R5 capturing on idle bus", {31'b0, capturing}, 1);
        repeat (3) @(negedge clk);

        // R6 halt on idle bus: DRAIN one cycle, then OFF
        wr(A_CTRL, 32'd0, 4'b0001);
        @(negedge clk);
        check("R6 drain keeps capturing", {31'b0, capturing}, 1);
        @(negedge clk);
        check("R6 off after idle drain", {31'b0, capturing}, 0);
        check("R7 active port", 32'(active_time), 32'(cap_seen));
        rd(A_ACT, 32'(cap_seen), "R7 active read");

        // R3 ignored writes
        wr(A_CTRL, 32'd1, 4'b0010);
        repeat (3) @(negedge clk);
        check("R3 strb0 low ignored", {31'b0, capturing}, 0);
        rd(A_CTRL, 32'd0, "R3 ctrl after ignored");
        wr(7'd20, 32'd1, 4'b1111);
        repeat (3) @(negedge clk);
        check("R3 other address ignored", {31'b0, capturing}, 0);

        // R4/R5 start while a read is outstanding
        mon_ar();
        wr(A_CTRL, 32'd1, 4'b0001);
        repeat (4) @(negedge clk);
        check("R5 start held while busy", {31'b0, capturing}, 0);
        rd(A_CTRL, 32'd1, "R9 start pending bit");
        mon_rlast();
        @(negedge clk);
        check("R4 idle registered", {31'b0, capturing}, 0);
        @(negedge clk);
        check("R4 capture after drain", {31'b0, capturing}, 1);

        // R6 stop while a write is outstanding
        mon_aw();
        wr(A_CTRL, 32'd0, 4'b0001);
        repeat (4) @(negedge clk);
        check("R6 stop held while busy", {31'b0, capturing}, 1);
        rd(A_CTRL, 32'd4, "R9 capturing bit");
        mon_wlast();
        @(negedge clk);
        check("R6 held until response", {31'b0, capturing}, 1);
        mon_b();
        @(negedge clk);
        check("R6 one more cycle", {31'b0, capturing}, 1);
        @(negedge clk);
        check("R6 stopped at idle", {31'b0, capturing}, 0);
        rd(A_ACT, 32'(cap_seen), "R7 active after stop");
        repeat (5) @(negedge clk);
        rd(A_ACT, 32'(cap_seen), "R7 active holds");

        // R8 clear while capturing
        wr(A_CTRL, 32'd1, 4'b0001);
        repeat (5) @(negedge clk);
        check("R5 capturing before clear", {31'b0, capturing}, 1);
        wr(A_CTRL, 32'd2, 4'b0001);
        @(negedge clk);
        check("R8 capturing forced low", {31'b0, capturing}, 0);
        check("R8 clear pulse high", {31'b0, clear_pulse}, 1);
        @(negedge clk);
        check("R8 clear pulse one cycle", {31'b0, clear_pulse}, 0);
        check("R8 active port zero", 32'(active_time), 0);
        rd(A_ACT, 32'd0, "R8 active read zero");
        rd(A_CTRL, 32'd0, "R8 ctrl after clear");

        repeat (3) @(negedge clk);
        check("R9 all reads returned", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule